// File: doc/BRIEF.md
# POST Checkpoint Beep Sequencer

This block watches a simple I/O write bus for writes to the checkpoint port at address 80h. It keeps the last byte written there as the current checkpoint code and presents it on an output. Writes to any other address leave the stored code alone.

When the error trigger is pulsed while the block is idle, the block takes a copy of the stored code and plays it on a speaker tone-enable. The copy is cut into four 2-bit fields. Each field becomes a burst of beeps: the field value plus one, so every burst has one to four beeps. Bursts are played from the top field to the bottom one. A code of 20h therefore sounds as 1-3-1-1.

Parameters set three lengths in clock cycles: how long a beep sounds, the silence between beeps of one burst, and the longer pause between bursts. A busy flag covers the whole pattern. The block does not synthesise the tone waveform and does not drive the speaker itself.

Top module: `post_beep_seq`

## Requirements
- R1: A cycle with `io_wr` high and `io_addr` equal to 0x0080 loads `io_data` into `code_q`, visible from the next cycle.
- R2: A write to any address other than 0x0080 leaves `code_q` unchanged.
- R3: `err_trig` sampled high while `busy` is low raises both `busy` and `spk_en` in the next cycle. The first beep starts there.
- R4: The pattern has four bursts, played in this order: bits 7:6, bits 5:4, bits 3:2, bits 1:0. A burst for field value v has v+1 beeps.
- R5: Each beep holds `spk_en` high for exactly BEEP_ON cycles. Beeps within one burst are separated by exactly BEEP_OFF low cycles.
- R6: Consecutive bursts are separated by exactly GROUP_GAP low cycles. No pause follows the last burst: `busy` falls in the cycle right after the final beep's last high cycle.
- R7: Code 20h produces beep bursts of 1, 3, 1 and 1.
- R8: `err_trig` pulses while `busy` is high are ignored. The pattern in progress and its length are unchanged.
- R9: Port writes during a pattern update `code_q` at once. The sound still follows the copy of `code_q` held before the triggering edge.
- R10: While `rst_n` is low, `code_q` is 00h and both `spk_en` and `busy` are low. This holds immediately, even in the middle of a pattern.
- R11: Code writes alone never raise `spk_en` or `busy`. Only `err_trig` starts a pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_addr | input | ADDR_W (16) | I/O write address |
| io_data | input | 8 | I/O write data |
| io_wr | input | 1 | Write strobe, one cycle per write |
| err_trig | input | 1 | Error flag; starts a pattern when idle |
| spk_en | output | 1 | Speaker tone enable |
| busy | output | 1 | High while a pattern plays |
| code_q | output | 8 | Last code written to the checkpoint port |

## Verification
The assertions assume that all three durations are at least one cycle. Under that assumption a beep can never touch the next one, and a falling tone enable always marks the end of a whole beep. They also assume that `err_trig` and the write bus change only between clock edges. The bench meets both conditions: it uses 4/3/10-cycle durations and drives every input at the falling edge. Its random codes, stray writes to neighbouring addresses, and triggers and writes placed inside a pattern all fall within these limits.

// File: rtl/post_beep_pkg.sv
package post_beep_pkg;

  localparam int unsigned FIELD_W = 2;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_TONE = 2'd1,
    SEQ_HUSH = 2'd2,
    SEQ_GAP  = 2'd3
  } seq_state_e;

endpackage

// File: rtl/pbs_rst_sync.sv
module pbs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/pbs_code_port.sv
module pbs_code_port #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned CODE_W    = 8,
  parameter int unsigned PORT_ADDR = 32'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [CODE_W-1:0] io_data,
  input  logic              io_wr,
  output logic [CODE_W-1:0] code_q
);

  localparam logic [ADDR_W-1:0] HIT_ADDR = PORT_ADDR[ADDR_W-1:0];

  logic              hit;
  logic [CODE_W-1:0] code_d;

  always_comb begin
    hit    = io_wr && (io_addr == HIT_ADDR);
    code_d = io_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (hit) begin
      code_q <= code_d;
    end
  end

  AST_PORT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == HIT_ADDR) |=> (code_q == $past(io_data))); // R1

  AST_OTHER_PORT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!(io_wr && io_addr == HIT_ADDR)) |=> $stable(code_q)); // R2

endmodule

// File: rtl/pbs_interval_timer.sv
module pbs_interval_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) begin
      cnt_d = load_val;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/pbs_sequencer.sv
module pbs_sequencer
  import post_beep_pkg::*;
#(
  parameter int unsigned CODE_W    = 8,
  parameter int unsigned BEEP_ON   = 4,
  parameter int unsigned BEEP_OFF  = 3,
  parameter int unsigned GROUP_GAP = 10,
  parameter int unsigned CNT_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_trig,
  input  logic [CODE_W-1:0] code_q,
  input  logic              tmr_expired,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  output logic              spk_en,
  output logic              busy
);

  localparam int unsigned NGRP  = CODE_W / FIELD_W;
  localparam int unsigned GRP_W = (NGRP > 1) ? $clog2(NGRP) : 1;
  localparam logic [CNT_W-1:0] ON_LD   = CNT_W'(BEEP_ON - 1);
  localparam logic [CNT_W-1:0] OFF_LD  = CNT_W'(BEEP_OFF - 1);
  localparam logic [CNT_W-1:0] GAP_LD  = CNT_W'(GROUP_GAP - 1);
  localparam logic [GRP_W-1:0] TOP_GRP = GRP_W'(NGRP - 1);

  seq_state_e         state_q, state_d;
  logic [CODE_W-1:0]  snap_q, snap_d;
  logic [GRP_W-1:0]   grp_q, grp_d;
  logic [FIELD_W-1:0] left_q, left_d;
  logic [GRP_W-1:0]   nxt_grp;
  logic               snap_en;

  always_comb begin
    state_d  = state_q;
    snap_d   = snap_q;
    grp_d    = grp_q;
    left_d   = left_q;
    snap_en  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = ON_LD;
    nxt_grp  = grp_q - 1'b1;
    case (state_q)
      SEQ_IDLE: begin
        if (err_trig) begin
          state_d  = SEQ_TONE;
          snap_en  = 1'b1;
          snap_d   = code_q;
          grp_d    = TOP_GRP;
          left_d   = code_q[CODE_W-1 -: FIELD_W];
          tmr_load = 1'b1;
          tmr_val  = ON_LD;
        end
      end
      SEQ_TONE: begin
        if (tmr_expired) begin
          if (left_q != '0) begin
            state_d  = SEQ_HUSH;
            left_d   = left_q - 1'b1;
            tmr_load = 1'b1;
            tmr_val  = OFF_LD;
          end else if (grp_q != '0) begin
            state_d  = SEQ_GAP;
            grp_d    = nxt_grp;
            left_d   = snap_q[{nxt_grp, 1'b0} +: FIELD_W];
            tmr_load = 1'b1;
            tmr_val  = GAP_LD;
          end else begin
            state_d = SEQ_IDLE;
          end
        end
      end
      SEQ_HUSH, SEQ_GAP: begin
        if (tmr_expired) begin
          state_d  = SEQ_TONE;
          tmr_load = 1'b1;
          tmr_val  = ON_LD;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      grp_q   <= '0;
      left_q  <= '0;
    end else begin
      state_q <= state_d;
      grp_q   <= grp_d;
      left_q  <= left_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
    end else if (snap_en) begin
      snap_q <= snap_d;
    end
  end

  assign spk_en = (state_q == SEQ_TONE);
  assign busy   = (state_q != SEQ_IDLE);

  // checker counter: length of the current tone run
  logic [CNT_W-1:0] tone_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tone_run_q <= '0;
    end else if (spk_en) begin
      tone_run_q <= tone_run_q + 1'b1;
    end else begin
      tone_run_q <= '0;
    end
  end

  AST_START_TONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && err_trig) |=> (busy && spk_en)); // R3

  AST_TONE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spk_en) |-> ($past(tone_run_q) == ON_LD)); // R5

  AST_NO_TRAILING_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(spk_en)); // R6

  AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(snap_q)); // R9

  AST_ONLY_TRIG_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !err_trig) |=> !busy); // R11

endmodule

// File: rtl/post_beep_seq.sv
module post_beep_seq #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned PORT_ADDR = 32'h80,
  parameter int unsigned BEEP_ON   = 4,
  parameter int unsigned BEEP_OFF  = 3,
  parameter int unsigned GROUP_GAP = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_data,
  input  logic              io_wr,
  input  logic              err_trig,
  output logic              spk_en,
  output logic              busy,
  output logic [7:0]        code_q
);

  localparam int unsigned CODE_W  = 8;
  localparam int unsigned MAX_A   = (BEEP_ON > BEEP_OFF) ? BEEP_ON : BEEP_OFF;
  localparam int unsigned MAX_DUR = (MAX_A > GROUP_GAP) ? MAX_A : GROUP_GAP;
  localparam int unsigned CNT_W   = (MAX_DUR > 1) ? $clog2(MAX_DUR + 1) : 1;

  logic             rst_sync_n;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;

  pbs_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pbs_code_port #(
    .ADDR_W    (ADDR_W),
    .CODE_W    (CODE_W),
    .PORT_ADDR (PORT_ADDR)
  ) u_code_port (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .io_addr (io_addr),
    .io_data (io_data),
    .io_wr   (io_wr),
    .code_q  (code_q)
  );

  pbs_interval_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  pbs_sequencer #(
    .CODE_W    (CODE_W),
    .BEEP_ON   (BEEP_ON),
    .BEEP_OFF  (BEEP_OFF),
    .GROUP_GAP (GROUP_GAP),
    .CNT_W     (CNT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .err_trig    (err_trig),
    .code_q      (code_q),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .spk_en      (spk_en),
    .busy        (busy)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync_n |-> (!spk_en && !busy && code_q == 8'h00)); // R10

endmodule

// File: tb/post_beep_seq_bench.sv
module post_beep_seq_bench;

  localparam int ON  = 4;
  localparam int OFF = 3;
  localparam int GAP = 10;

  logic        clk;
  logic        rst_n;
  logic [15:0] io_addr;
  logic [7:0]  io_data;
  logic        io_wr;
  logic        err_trig;
  logic        spk_en;
  logic        busy;
  logic [7:0]  code_q;

  int total;
  int bad;
  bit done;

  post_beep_seq #(
    .ADDR_W    (16),
    .PORT_ADDR (32'h80),
    .BEEP_ON   (ON),
    .BEEP_OFF  (OFF),
    .GROUP_GAP (GAP)
  ) u_post_beep_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .io_data  (io_data),
    .io_wr    (io_wr),
    .err_trig (err_trig),
    .spk_en   (spk_en),
    .busy     (busy),
    .code_q   (code_q)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic bit exp_spk(input logic [7:0] c, input int k);
    int t;
    t = k;
    for (int g = 3; g >= 0; g--) begin
      int n;
      n = int'(c[2*g +: 2]) + 1;
      for (int b = 0; b < n; b++) begin
        if (t < ON) return 1'b1;
        t -= ON;
        if (b < n - 1) begin
          if (t < OFF) return 1'b0;
          t -= OFF;
        end
      end
      if (g > 0) begin
        if (t < GAP) return 1'b0;
        t -= GAP;
      end
    end
    return 1'b0;
  endfunction

  function automatic int exp_len(input logic [7:0] c);
    int len;
    len = 3 * GAP;
    for (int g = 0; g < 4; g++) begin
      int n;
      n = int'(c[2*g +: 2]) + 1;
      len += n * ON + (n - 1) * OFF;
    end
    return len;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    io_addr = a;
    io_data = d;
    io_wr   = 1'b1;
    @(negedge clk);
    io_wr   = 1'b0;
  endtask

  // plays code c; optional retrigger at cycle rt_k and port write at wr_k
  task automatic play(input logic [7:0] c, input string tag,
                      input int rt_k, input int wr_k, input logic [7:0] wr_v);
    int len;
    int bad_k;
    bit act_s;
    bit act_b;
    bit exp_s;
    wr(16'h0080, c);
    chk(code_q == c, "R1 capture before play", code_q, c);
    len   = exp_len(c);
    bad_k = -1;
    exp_s = 1'b0;
    act_s = 1'b0;
    act_b = 1'b0;
    err_trig = 1'b1;
    @(negedge clk);
    err_trig = 1'b0;
    for (int k = 0; k <= len; k++) begin
      if (bad_k < 0 && (spk_en != exp_spk(c, k) || busy != (k < len))) begin
        bad_k = k;
        act_s = spk_en;
        act_b = busy;
        exp_s = exp_spk(c, k);
      end
      err_trig = (k == rt_k);
      io_wr    = (k == wr_k);
      io_addr  = 16'h0080;
      io_data  = wr_v;
      @(negedge clk);
    end
    err_trig = 1'b0;
    io_wr    = 1'b0;
    if (bad_k >= 0)
      $display("  cycle %0d of pattern %0h: spk=%0b busy=%0b exp_spk=%0b",
               bad_k, c, act_s, act_b, exp_s);
    chk(bad_k < 0, tag, bad_k, -1);
    if (wr_k >= 0)
      chk(code_q == wr_v, "R9 code_q updated during play", code_q, wr_v);
  endtask

  initial begin
    done = 1'b0;
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] c;
    bit quiet;
    total    = 0;
    bad      = 0;
    rst_n    = 1'b0;
    io_addr  = '0;
    io_data  = '0;
    io_wr    = 1'b0;
    err_trig = 1'b0;
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(code_q == 8'h00 && !spk_en && !busy, "R10 reset state",
        {spk_en, busy, code_q}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R2
    wr(16'h0080, 8'h5A);
    chk(code_q == 8'h5A, "R1 write to port 80h", code_q, 8'h5A);
    wr(16'h0081, 8'hC3);
    chk(code_q == 8'h5A, "R2 write to 81h ignored", code_q, 8'h5A);
    wr(16'h0180, 8'hC3);
    chk(code_q == 8'h5A, "R2 write to 180h ignored", code_q, 8'h5A);

    // R11: writes alone never start a pattern
    quiet = 1'b1;
    for (int i = 0; i < 20; i++) begin
      wr((i % 2 == 0) ? 16'h0080 : 16'(($urandom % 16'hFFFF) | 16'h1), 8'($urandom));
      if (spk_en || busy) quiet = 1'b0;
    end
    chk(quiet, "R11 no beep without error trigger", quiet, 1);

    // directed patterns
    play(8'h20, "R7 code 20h gives 1-3-1-1", -1, -1, 8'h00);
    play(8'hE4, "R4 field order 4-3-2-1", -1, -1, 8'h00);
    play(8'h00, "R6 single beeps and gaps", -1, -1, 8'h00);
    play(8'hFF, "R5 four beeps per burst", -1, -1, 8'h00);
    play(8'h1B, "R8 retrigger while busy ignored R3", 5, -1, 8'h00);
    play(8'h93, "R9 snapshot kept during write", -1, 20, 8'h3C);

    // random codes with random retriggers and writes inside the pattern
    for (int i = 0; i < 12; i++) begin
      int rk;
      int wk;
      c  = 8'($urandom);
      rk = ($urandom % 2 == 0) ? int'($urandom % 40) : -1;
      wk = ($urandom % 2 == 0) ? int'($urandom % 40) : -1;
      play(c, "R4 R5 R6 R8 random pattern", rk, wk, 8'($urandom));
    end

    // R10: reset in the middle of a pattern
    wr(16'h0080, 8'hFF);
    err_trig = 1'b1;
    @(negedge clk);
    err_trig = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(code_q == 8'h00 && !spk_en && !busy, "R10 reset mid pattern",
        {spk_en, busy, code_q}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !spk_en, "R10 idle after reset release", {spk_en, busy}, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule